// File: doc/BRIEF.md
# Video Clamp and Gain Controller

This block is the digital half of the black-level and amplitude loop of a video ADC front end. On every clock it takes one 9-bit sample from the converter. It uses the upper eight bits of the sample as a level code and compares that code with fixed targets. The comparisons are only made inside the horizontal timing windows. From them the block produces two results: a clamp nudge command for the analog offset circuit, and an 8-bit gain word for the programmable amplifier.

Clamp decisions are made sample by sample inside the clamp pulse. The target is code 60 on a luma channel and code 128 on a chroma channel. The gain word moves in two ways. A sample that overshoots the white peak cuts the gain at once, by four codes. The lowest code seen during each horizontal sync pulse nudges the gain by one code, up or down, once per qualifying line. While vertical blanking is active, neither the clamp nor the gain acts.

Top module: `vid_clamp_gain_ctrl`

## Requirements
- R1: While rst_n is low, and after it rises until the first update, gain_o is 128, clamp_cmd_o is 2'b00, and gain_fast_o and gain_slow_o are 0.
- R2: The level code is sample_i[8:1], and sample_i[0] is ignored. In a cycle where hclamp_i is 1 and vblank_i is 0, the next cycle's clamp_cmd_o is 2'b01 (raise) if the code is below the clamp target, 2'b11 (lower) if it is above, and 2'b00 if it is equal.
- R3: The clamp target is code 60 when chroma_sel_i is 0 and code 128 when chroma_sel_i is 1.
- R4: A cycle with hclamp_i at 0 gives clamp_cmd_o 2'b00 in the next cycle, whatever the code is.
- R5: A cycle with code 255 (above the white peak of 254) and vblank_i at 0 lowers gain_o by 4 in the next cycle and pulses gain_fast_o for that one cycle. Code 254 has no effect.
- R6: The block tracks the minimum code over each high period of hsync_i. On a qualifying line end it acts on that minimum. A minimum above 1 raises gain_o by 1. A minimum of 0 lowers gain_o by 1. Either step pulses gain_slow_o in the next cycle. A minimum of exactly 1 holds the gain and gives no pulse.
- R7: A line end is the first cycle in which hsync_i is low after being high. A line counter advances on every line end, including line ends during blanking. Only every SLOW_LINES-th line end after reset qualifies for a slow step. With the default of 2, these are the 2nd, 4th, 6th and so on.
- R8: gain_o saturates at 255 and at 0 and never wraps. A step taken at a limit still pulses its strobe.
- R9: In a cycle with vblank_i at 1, the block issues no clamp command and no fast step. A line end in such a cycle takes no slow step, but it still advances the line counter.
- R10: If a white-peak sample falls in the same cycle as a qualifying line end, only the fast decrease of 4 is applied. The slow step of that line is dropped and is not deferred.
- R11: gain_o changes only in a cycle where gain_fast_o or gain_slow_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 9 | ADC sample; bits 8:1 form the level code |
| hsync_i | input | 1 | Horizontal sync pulse, active high |
| hclamp_i | input | 1 | Horizontal clamp window, active high |
| vblank_i | input | 1 | Vertical blanking flag, active high |
| chroma_sel_i | input | 1 | 0 selects the luma clamp target, 1 the chroma target |
| clamp_cmd_o | output | 2 | Registered clamp nudge: 01 raise, 11 lower, 00 hold |
| gain_o | output | 8 | Registered amplifier gain word |
| gain_fast_o | output | 1 | One-cycle strobe of a white-peak decrease |
| gain_slow_o | output | 1 | One-cycle strobe of a line-based gain step |

## Verification
The fast white-peak decrease and the slow line step are the two gain actions that can fall in the same cycle. To provoke the collision, the line counter is first brought to the count just before a qualifying line end. The next sync pulse then ends on a sample with code 255. The result is judged correct when gain_o drops by exactly 4, gain_fast_o is high, gain_slow_o stays low, and the following qualifying line end, SLOW_LINES line ends later, steps the gain normally.

// File: rtl/vcg_pkg.sv
package vcg_pkg;

  localparam int SAMPLE_W     = 9;
  localparam int CODE_W       = SAMPLE_W - 1;
  localparam int GAIN_W       = 8;
  localparam int GAIN_MAX     = (1 << GAIN_W) - 1;
  localparam int WHITE_PEAK   = 254;
  localparam int SYNC_BOTTOM  = 1;
  localparam int LUMA_CLAMP   = 60;
  localparam int CHROMA_CLAMP = 128;
  localparam int FAST_STEP    = 4;
  localparam int SLOW_STEP    = 1;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [GAIN_W-1:0] gain_t;

  typedef enum logic [1:0] {
    CLP_HOLD  = 2'b00,
    CLP_RAISE = 2'b01,
    CLP_LOWER = 2'b11
  } clamp_cmd_e;

  // drop the sub-code LSB of a converter sample
  function automatic code_t code_of(input logic [SAMPLE_W-1:0] s);
    return s[SAMPLE_W-1:1];
  endfunction

  // clamp target for the selected channel
  function automatic code_t clamp_target(input logic chroma);
    return chroma ? code_t'(CHROMA_CLAMP) : code_t'(LUMA_CLAMP);
  endfunction

  // add a signed delta to the gain, clipped to the legal range
  function automatic gain_t sat_step(input gain_t g, input int delta);
    int t;
    t = int'(g) + delta;
    if (t < 0) t = 0;
    if (t > GAIN_MAX) t = GAIN_MAX;
    return gain_t'(t);
  endfunction

  // clamp command for one sample against one target
  function automatic clamp_cmd_e clamp_decide(input code_t c, input code_t tgt);
    if (c < tgt) return CLP_RAISE;
    if (c > tgt) return CLP_LOWER;
    return CLP_HOLD;
  endfunction

endpackage

// File: rtl/vcg_clamp_eval.sv
module vcg_clamp_eval
  import vcg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  code_t      code_i,
  input  logic       hclamp_i,
  input  logic       vblank_i,
  input  logic       chroma_sel_i,
  output clamp_cmd_e cmd_o
);

  logic       window_open;
  code_t      target;
  clamp_cmd_e cmd_d;

  assign window_open = hclamp_i && !vblank_i;
  assign target      = clamp_target(chroma_sel_i);

  always_comb begin
    cmd_d = CLP_HOLD;
    if (window_open) cmd_d = clamp_decide(code_i, target);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_o <= CLP_HOLD;
    else        cmd_o <= cmd_d;
  end

  // R4 / R9: no command follows a cycle outside an open window
  p_idle_outside_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!hclamp_i || vblank_i) |-> cmd_o == CLP_HOLD);

  // R2: a raise follows an in-window sample below its target
  p_raise_below_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && hclamp_i && !vblank_i && (code_i < clamp_target(chroma_sel_i)))
    |-> cmd_o == CLP_RAISE);

endmodule

// File: rtl/vcg_sync_track.sv
module vcg_sync_track
  import vcg_pkg::*;
#(
  parameter int SLOW_LINES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hsync_i,
  input  code_t code_i,
  output logic  line_end_o,
  output logic  step_take_o,
  output logic  step_up_o
);

  localparam int LCW = (SLOW_LINES > 1) ? $clog2(SLOW_LINES) : 1;

  logic  hs_q;
  code_t min_q;
  logic  rise;
  logic  last_line;

  assign rise       = hsync_i && !hs_q;
  assign line_end_o = hs_q && !hsync_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      min_q <= '1;
    end else begin
      hs_q <= hsync_i;
      if (hsync_i) begin
        if (rise || code_i < min_q) min_q <= code_i;
      end
    end
  end

  generate
    if (SLOW_LINES > 1) begin : g_line_cnt
      logic [LCW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (line_end_o) cnt_q <= (cnt_q == LCW'(SLOW_LINES - 1)) ? '0 : cnt_q + 1'b1;
      end
      assign last_line = (cnt_q == LCW'(SLOW_LINES - 1));
    end else begin : g_every_line
      assign last_line = 1'b1;
    end
  endgenerate

  assign step_take_o = line_end_o && last_line && (min_q != code_t'(SYNC_BOTTOM));
  assign step_up_o   = min_q > code_t'(SYNC_BOTTOM);

  // R6: within a pulse the tracked minimum never exceeds the last code seen
  p_min_follows_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync_i && hs_q) |=> min_q <= $past(code_i));

endmodule

// File: rtl/vcg_gain_reg.sv
module vcg_gain_reg
  import vcg_pkg::*;
#(
  parameter int GAIN_INIT = 128
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  vblank_i,
  input  logic  peak_hit_i,
  input  logic  line_step_i,
  input  logic  step_up_i,
  output gain_t gain_o,
  output logic  fast_o,
  output logic  slow_o
);

  logic  do_fast;
  logic  do_slow;
  gain_t gain_d;

  assign do_fast = peak_hit_i && !vblank_i;
  assign do_slow = line_step_i && !vblank_i && !do_fast;

  always_comb begin
    gain_d = gain_o;
    if (do_fast)      gain_d = sat_step(gain_o, -FAST_STEP);
    else if (do_slow) gain_d = sat_step(gain_o, step_up_i ? SLOW_STEP : -SLOW_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_o <= gain_t'(GAIN_INIT);
      fast_o <= 1'b0;
      slow_o <= 1'b0;
    end else begin
      gain_o <= gain_d;
      fast_o <= do_fast;
      slow_o <= do_slow;
    end
  end

  // R5 / R8: a fast strobe pairs with a clipped drop of four codes
  p_fast_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fast_o |-> gain_o == sat_step($past(gain_o), -FAST_STEP));

  // R11: without a strobe the gain word holds
  p_gain_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_o && !slow_o) |-> $stable(gain_o));

  // R8: an upward slow step stays in range and never wraps to a small value
  p_no_wrap_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_o && $past(step_up_i)) |-> gain_o >= $past(gain_o));

endmodule

// File: rtl/vid_clamp_gain_ctrl.sv
module vid_clamp_gain_ctrl
  import vcg_pkg::*;
#(
  parameter int SLOW_LINES = 2,
  parameter int GAIN_INIT  = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                hsync_i,
  input  logic                hclamp_i,
  input  logic                vblank_i,
  input  logic                chroma_sel_i,
  output logic [1:0]          clamp_cmd_o,
  output logic [GAIN_W-1:0]   gain_o,
  output logic                gain_fast_o,
  output logic                gain_slow_o
);

  code_t      code;
  logic       unused_lsb;
  logic       peak_hit;
  logic       line_end;
  logic       step_take;
  logic       step_up;
  clamp_cmd_e clamp_cmd;

  assign code       = code_of(sample_i);
  assign unused_lsb = sample_i[0];
  assign peak_hit   = code > code_t'(WHITE_PEAK);

  vcg_clamp_eval u_clamp (
    .clk          (clk),
    .rst_n        (rst_n),
    .code_i       (code),
    .hclamp_i     (hclamp_i),
    .vblank_i     (vblank_i),
    .chroma_sel_i (chroma_sel_i),
    .cmd_o        (clamp_cmd)
  );

  vcg_sync_track #(.SLOW_LINES(SLOW_LINES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .hsync_i     (hsync_i),
    .code_i      (code),
    .line_end_o  (line_end),
    .step_take_o (step_take),
    .step_up_o   (step_up)
  );

  vcg_gain_reg #(.GAIN_INIT(GAIN_INIT)) u_gain (
    .clk         (clk),
    .rst_n       (rst_n),
    .vblank_i    (vblank_i),
    .peak_hit_i  (peak_hit),
    .line_step_i (step_take),
    .step_up_i   (step_up),
    .gain_o      (gain_o),
    .fast_o      (gain_fast_o),
    .slow_o      (gain_slow_o)
  );

  assign clamp_cmd_o = clamp_cmd;

  // R10: the two gain strobes never coincide
  p_strobes_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(gain_fast_o && gain_slow_o));

  // R9: blanking suppresses every gain strobe
  p_blank_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vblank_i) |-> (!gain_fast_o && !gain_slow_o));

  // R7: a slow strobe only follows a line end
  p_slow_on_line_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gain_slow_o |-> $past(line_end));

endmodule

// File: tb/test_vid_clamp_gain_ctrl.sv
module test_vid_clamp_gain_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int SLOW_LINES = 2;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] sample_i = '0;
  logic       hsync_i = 1'b0;
  logic       hclamp_i = 1'b0;
  logic       vblank_i = 1'b0;
  logic       chroma_sel_i = 1'b0;
  logic [1:0] clamp_cmd_o;
  logic [7:0] gain_o;
  logic       gain_fast_o;
  logic       gain_slow_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string cur_req = "R1";

  // requirement-level model state
  int m_gain = 128;
  int m_cnt  = 0;
  int m_min  = 255;
  bit m_hs   = 1'b0;

  vid_clamp_gain_ctrl #(.SLOW_LINES(SLOW_LINES)) i_vid_clamp_gain_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .hsync_i(hsync_i),
    .hclamp_i(hclamp_i), .vblank_i(vblank_i), .chroma_sel_i(chroma_sel_i),
    .clamp_cmd_o(clamp_cmd_o), .gain_o(gain_o),
    .gain_fast_o(gain_fast_o), .gain_slow_o(gain_slow_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int clip(input int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  // one clock of stimulus, checked against the model after the edge
  task automatic cyc(input int code, input bit hs, input bit hc, input bit vb,
                     input bit cs, input bit lsb = 1'b0);
    int tgt, e_cl, e_fast, e_slow;
    bit lend;
    sample_i = {code[7:0], lsb};
    hsync_i = hs; hclamp_i = hc; vblank_i = vb; chroma_sel_i = cs;
    tgt = cs ? 128 : 60;
    e_cl = 0;
    if (hc && !vb) e_cl = (code < tgt) ? 1 : ((code > tgt) ? 3 : 0);
    lend = m_hs && !hs;
    e_fast = 0; e_slow = 0;
    if (!vb && code == 255) begin
      e_fast = 1; m_gain = clip(m_gain - 4);
    end else if (!vb && lend && m_cnt == SLOW_LINES - 1 && m_min != 1) begin
      e_slow = 1; m_gain = clip(m_gain + ((m_min > 1) ? 1 : -1));
    end
    if (lend) m_cnt = (m_cnt + 1) % SLOW_LINES;
    if (hs) begin
      if (!m_hs || code < m_min) m_min = code;
    end
    m_hs = hs;
    @(negedge clk);
    chk({cur_req, " clamp"}, int'(clamp_cmd_o), e_cl);
    chk({cur_req, " gain"},  int'(gain_o), m_gain);
    chk({cur_req, " fast"},  int'(gain_fast_o), e_fast);
    chk({cur_req, " slow"},  int'(gain_slow_o), e_slow);
  endtask

  // one video line: three sync samples, then two quiet samples
  task automatic line(input int min_code, input bit vb = 1'b0, input int end_code = 100);
    cyc(min_code + 20 > 254 ? 254 : min_code + 20, 1'b1, 1'b0, vb, 1'b0);
    cyc(min_code, 1'b1, 1'b0, vb, 1'b0);
    cyc(min_code + 3 > 254 ? 254 : min_code + 3, 1'b1, 1'b0, vb, 1'b0);
    cyc(end_code, 1'b0, 1'b0, vb, 1'b0);
    cyc(100, 1'b0, 1'b0, vb, 1'b0);
  endtask

  task automatic t_reset;
    cur_req = "R1";
    chk("R1 gain at reset", int'(gain_o), 128);
    chk("R1 clamp at reset", int'(clamp_cmd_o), 0);
    chk("R1 fast at reset", int'(gain_fast_o), 0);
    chk("R1 slow at reset", int'(gain_slow_o), 0);
  endtask

  task automatic t_clamp_luma;
    cur_req = "R2";
    cyc(59, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 luma below raises", int'(clamp_cmd_o), 1);
    cyc(60, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R2 luma equal holds, lsb ignored", int'(clamp_cmd_o), 0);
    cyc(61, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 luma above lowers", int'(clamp_cmd_o), 3);
  endtask

  task automatic t_clamp_chroma;
    cur_req = "R3";
    cyc(127, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R3 chroma below raises", int'(clamp_cmd_o), 1);
    cyc(128, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R3 chroma equal holds", int'(clamp_cmd_o), 0);
    cyc(100, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R3 code 100 raises on chroma", int'(clamp_cmd_o), 1);
    cyc(100, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3 code 100 lowers on luma", int'(clamp_cmd_o), 3);
  endtask

  task automatic t_clamp_outside;
    cur_req = "R4";
    cyc(0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 no clamp outside window", int'(clamp_cmd_o), 0);
    cyc(200, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R4 no clamp outside window chroma", int'(clamp_cmd_o), 0);
  endtask

  task automatic t_white_peak;
    int g0;
    cur_req = "R5";
    g0 = int'(gain_o);
    cyc(254, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5 code 254 leaves gain", int'(gain_o), g0);
    cyc(255, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5 peak drops gain by 4", int'(gain_o), g0 - 4);
    chk("R5 fast strobe", int'(gain_fast_o), 1);
    cyc(255, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5 second peak drops again", int'(gain_o), g0 - 8);
    cyc(100, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R11 gain holds with no strobe", int'(gain_o), g0 - 8);
  endtask

  task automatic t_sync_lines;
    int g0;
    cur_req = "R7";
    while (m_cnt != 0) line(1);
    g0 = int'(gain_o);
    line(5);
    chk("R7 first line end does not qualify", int'(gain_o), g0);
    cur_req = "R6";
    line(5);
    chk("R6 high sync bottom raises gain", int'(gain_o), g0 + 1);
    line(0); line(0);
    chk("R6 deep sync bottom lowers gain", int'(gain_o), g0);
    line(1); line(1);
    chk("R6 exact bottom holds gain", int'(gain_o), g0);
  endtask

  task automatic t_vblank;
    int g0;
    cur_req = "R9";
    g0 = int'(gain_o);
    cyc(255, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R9 no fast step in blanking", int'(gain_o), g0);
    chk("R9 no clamp in blanking", int'(clamp_cmd_o), 0);
    line(5, 1'b1); line(5, 1'b1);
    chk("R9 no slow step in blanking", int'(gain_o), g0);
    cur_req = "R7";
    line(5); line(5);
    chk("R7 counter kept pace through blanking", int'(gain_o), g0 + 1);
  endtask

  task automatic t_collision;
    int g0;
    cur_req = "R10";
    if (m_cnt != SLOW_LINES - 1) line(1);
    g0 = int'(gain_o);
    cyc(30, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(10, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(255, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 fast wins at line end", int'(gain_o), g0 - 4);
    chk("R10 fast strobe set", int'(gain_fast_o), 1);
    chk("R10 slow strobe dropped", int'(gain_slow_o), 0);
    cyc(100, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 slow step not deferred", int'(gain_o), g0 - 4);
    line(5); line(5);
    chk("R10 next qualifying line steps", int'(gain_o), g0 - 3);
  endtask

  task automatic t_sat_high;
    cur_req = "R8";
    for (int i = 0; i < 600 && int'(gain_o) < 255; i++) line(5);
    chk("R8 gain reaches 255", int'(gain_o), 255);
    line(5); line(5);
    chk("R8 gain stays at 255", int'(gain_o), 255);
  endtask

  task automatic t_sat_low;
    cur_req = "R8";
    for (int i = 0; i < 70; i++) cyc(255, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 gain floors at 0", int'(gain_o), 0);
    chk("R8 strobe at floor", int'(gain_fast_o), 1);
    line(0); line(0);
    chk("R8 slow decrease stays at 0", int'(gain_o), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clamp_luma();
    t_clamp_chroma();
    t_clamp_outside();
    t_white_peak();
    t_sync_lines();
    t_vblank();
    t_collision();
    t_sat_high();
    t_sat_low();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule